// File: doc/BRIEF.md
# Single-Cycle Three-Instruction Processor Core

This block is a small 32-bit processor core that completes one instruction per clock period. It handles three instructions: a register-to-register sum, a word load, and a compare-equal branch whose following instruction always runs. The core holds a program counter and a bank of 32 general registers. It reads instructions through an instruction-fetch port and reads data words through a data-read port. Both ports are combinational: the memory behind each one must return the word for the presented address within the same cycle.

Each rising clock edge retires the instruction currently on the fetch port. The edge writes the destination register, if there is one, and advances the program counter. A taken branch does not change the very next fetch. It records a pending target, and the fetch after that one comes from the target. Any encoding outside the three supported instructions leaves every register as it was.

The reset input is asynchronous and active low. Its release passes through a two-stage synchroniser inside the core.

Top module: `tri_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 immediately, without waiting for a clock edge, and any pending branch redirect is discarded. After `rst_n` rises, the instruction at address 0 is retired on the third rising edge; the first two edges leave the PC at 0.
- R2: When no branch redirect is pending, every retiring edge advances `imem_addr` by 4.
- R3: An instruction with bits [31:26] = 000000 and bits [5:0] = 100000 writes the sum of register[bits 25:21] and register[bits 20:16] into register[bits 15:11]. The next instruction already sees the new value.
- R4: An instruction with bits [31:26] = 100011 drives `dmem_addr` with register[bits 25:21] plus the sign-extended bits [15:0]. It writes `dmem_rdata` into register[bits 20:16].
- R5: An instruction with bits [31:26] = 000100 whose register[bits 25:21] differs from its register[bits 20:16] lets fetch continue sequentially.
- R6: When that branch finds both registers equal, the next sequential instruction (the delay slot) still executes. The fetch after the slot comes from the branch's own address + 4 + 4 × sign-extended bits [15:0]. Negative offsets are included.
- R7: Register 0 always reads as zero, and a write aimed at it is discarded.
- R8: Any other value of bits [31:26], and opcode 000000 with any value of bits [5:0] other than 100000, changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Load address: base register plus sign-extended offset |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |

## Verification
The bound checker watches the program counter on every cycle. It checks sequential stepping, the sequential step into the delay slot, the jump to the recorded target one cycle later, and the forced zero address under reset. It also checks, cycle by cycle, that a source field of zero reads zero and that an unsupported opcode never raises the register write enable. Register contents are not visible at the ports, so the bench shows them through the load address. A load with zero offset from a register puts that register's value on `dmem_addr`. This is how the bench shows sums, loaded words, sign extension, the discarded write to register 0 and the no-op encodings. It also shows that a reset taken while a redirect is pending cancels that redirect.

// File: rtl/tri_core_pkg.sv
package tri_core_pkg;

  localparam int unsigned XLEN      = 32;
  localparam int unsigned REG_COUNT = 32;
  localparam int unsigned RIDX_W    = $clog2(REG_COUNT);

  // opcode field values in bits [31:26]
  localparam logic [5:0] OPC_REG  = 6'b000000;
  localparam logic [5:0] OPC_LOAD = 6'b100011;
  localparam logic [5:0] OPC_BREQ = 6'b000100;
  // function field value in bits [5:0] selecting the sum
  localparam logic [5:0] FN_SUM   = 6'b100000;

  typedef struct packed {
    logic [RIDX_W-1:0] src_a;
    logic [RIDX_W-1:0] src_b;
    logic [RIDX_W-1:0] dst;
    logic              rf_we;
    logic              sel_mem;
    logic              is_beq;
    logic [XLEN-1:0]   imm_sx;
  } dec_t;

endpackage

// File: rtl/tri_core_decode.sv
module tri_core_decode
  import tri_core_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic [5:0] opc;
  logic [5:0] fn;
  logic       hit_sum;
  logic       hit_load;

  assign opc      = instr[31:26];
  assign fn       = instr[5:0];
  assign hit_sum  = (opc == OPC_REG) && (fn == FN_SUM);
  assign hit_load = (opc == OPC_LOAD);

  always_comb begin
    dec.src_a   = instr[25:21];
    dec.src_b   = instr[20:16];
    dec.dst     = hit_sum ? instr[15:11] : instr[20:16];
    dec.rf_we   = hit_sum || hit_load;
    dec.sel_mem = hit_load;
    dec.is_beq  = (opc == OPC_BREQ);
    dec.imm_sx  = {{(XLEN-16){instr[15]}}, instr[15:0]};
  end

endmodule

// File: rtl/tri_core_regfile.sv
module tri_core_regfile #(
  parameter  int unsigned XLEN      = tri_core_pkg::XLEN,
  parameter  int unsigned REG_COUNT = tri_core_pkg::REG_COUNT,
  localparam int unsigned IW        = $clog2(REG_COUNT)
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [IW-1:0]   rd_idx_a,
  input  logic [IW-1:0]   rd_idx_b,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b
);

  logic [REG_COUNT-1:0][XLEN-1:0] bank;

  // entry 0 has no storage and always reads zero
  assign bank[0] = '0;

  for (genvar g = 1; g < REG_COUNT; g++) begin : g_reg
    logic [XLEN-1:0] q;
    logic            en;
    assign en = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (en) q <= wr_data;
    end
    assign bank[g] = q;
  end

  assign rd_a = bank[rd_idx_a];
  assign rd_b = bank[rd_idx_b];

endmodule

// File: rtl/tri_core_fetch.sv
module tri_core_fetch #(
  parameter int unsigned XLEN = tri_core_pkg::XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_taken,
  input  logic [XLEN-1:0] br_tgt,
  output logic [XLEN-1:0] pc
);

  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] tgt_q;
  logic            pend_q, pend_d;

  // next state: a pending redirect overrides the sequential step once
  always_comb begin
    pc_d   = pend_q ? tgt_q : pc_q + XLEN'(4);
    pend_d = br_taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      pend_q <= pend_d;
    end
  end

  // target storage is qualified by the pending flag, so it needs no reset
  always_ff @(posedge clk) begin
    if (br_taken) tgt_q <= br_tgt;
  end

  assign pc = pc_q;

endmodule

// File: rtl/tri_core.sv
module tri_core
  import tri_core_pkg::*;
#(
  parameter int unsigned XLEN      = tri_core_pkg::XLEN,
  parameter int unsigned REG_COUNT = tri_core_pkg::REG_COUNT
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int unsigned IW = $clog2(REG_COUNT);

  logic [1:0]      rst_sync_q;
  logic            core_rst_n;
  dec_t            dec;
  logic [XLEN-1:0] rs_val, rt_val;
  logic [XLEN-1:0] alu_sum, wr_data;
  logic            rf_we;
  logic            br_taken;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] pc;

  // asynchronous assertion, synchronous two-stage release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  tri_core_decode dec_i (
    .instr (imem_rdata),
    .dec   (dec)
  );

  tri_core_regfile #(.XLEN(XLEN), .REG_COUNT(REG_COUNT)) rf_i (
    .clk      (clk),
    .wr_en    (rf_we),
    .wr_idx   (dec.dst[IW-1:0]),
    .wr_data  (wr_data),
    .rd_idx_a (dec.src_a[IW-1:0]),
    .rd_idx_b (dec.src_b[IW-1:0]),
    .rd_a     (rs_val),
    .rd_b     (rt_val)
  );

  assign alu_sum   = rs_val + rt_val;
  assign dmem_addr = rs_val + dec.imm_sx;
  assign wr_data   = dec.sel_mem ? dmem_rdata : alu_sum;
  assign rf_we     = dec.rf_we && core_rst_n;

  assign br_taken  = dec.is_beq && (rs_val == rt_val);
  assign br_tgt    = pc + XLEN'(4) + {dec.imm_sx[XLEN-3:0], 2'b00};

  tri_core_fetch #(.XLEN(XLEN)) fetch_i (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .br_taken (br_taken),
    .br_tgt   (br_tgt),
    .pc       (pc)
  );

  assign imem_addr = pc;

endmodule

// File: rtl/tri_core_chk.sv
module tri_core_chk #(
  parameter int unsigned XLEN = tri_core_pkg::XLEN
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_rst_n,
  input logic [XLEN-1:0] imem_addr,
  input logic [31:0]     imem_rdata,
  input logic [XLEN-1:0] rs_val,
  input logic            rf_we,
  input logic            br_taken,
  input logic [XLEN-1:0] br_tgt
);

  AST_RESET_PC_ZERO: assert property (@(posedge clk)
    !rst_n |-> (imem_addr == '0)); // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!br_taken && !$past(br_taken)) |=> (imem_addr == $past(imem_addr) + XLEN'(4))); // R2

  AST_SLOT_SEQUENTIAL: assert property (@(posedge clk) disable iff (!core_rst_n)
    br_taken |=> (imem_addr == $past(imem_addr) + XLEN'(4))); // R6

  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!core_rst_n)
    br_taken |=> ##1 (imem_addr == $past(br_tgt, 2))); // R6

  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!core_rst_n)
    (imem_rdata[25:21] == 5'd0) |-> (rs_val == '0)); // R7

  AST_NOP_NO_WRITE: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((imem_rdata[31:26] != 6'b000000) && (imem_rdata[31:26] != 6'b100011)) |-> !rf_we); // R8

endmodule

bind tri_core tri_core_chk #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .rs_val     (rs_val),
  .rf_we      (rf_we),
  .br_taken   (br_taken),
  .br_tgt     (br_tgt)
);

// File: tb/tri_core_tb_top.sv
module tri_core_tb_top;

  logic        clk;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_rdata;
  logic [31:0] imem [32];
  int          n_checks;
  int          n_errors;
  bit          done;

  tri_core dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_rdata (dmem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign imem_rdata = imem[imem_addr[6:2]];
  // data memory model: each word equals its address plus 0x10000000
  assign dmem_rdata = dmem_addr + 32'h1000_0000;

  function automatic logic [31:0] enc_lw(input int rt, input int rs, input logic [15:0] off);
    return {6'b100011, 5'(rs), 5'(rt), off};
  endfunction
  function automatic logic [31:0] enc_add(input int rd, input int rs, input int rt, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_beq(input int rs, input int rt, input logic [15:0] off);
    return {6'b000100, 5'(rs), 5'(rt), off};
  endfunction

  // expected per retired cycle: {pc, check load address, load address, requirement}
  localparam int NROWS = 19;
  localparam logic [68:0] EXP [NROWS] = '{
    {32'd0,  1'b1, 32'h0000_0010, 4'd4},  // R4 lw r1
    {32'd4,  1'b1, 32'h0000_0020, 4'd4},  // R4 lw r2
    {32'd8,  1'b0, 32'h0,         4'd2},  // R2 add r3
    {32'd12, 1'b1, 32'h2000_0030, 4'd3},  // R3 sum seen next cycle
    {32'd16, 1'b0, 32'h0,         4'd2},  // R2 add into r0
    {32'd20, 1'b1, 32'h0000_0004, 4'd7},  // R7 r0 still zero
    {32'd24, 1'b1, 32'h1000_0008, 4'd4},  // R4 negative offset
    {32'd28, 1'b0, 32'h0,         4'd5},  // R5 beq not taken
    {32'd32, 1'b1, 32'h3000_0030, 4'd5},  // R5 sequential after beq
    {32'd36, 1'b0, 32'h0,         4'd6},  // R6 beq taken
    {32'd40, 1'b1, 32'h1000_0004, 4'd6},  // R6 delay slot runs
    {32'd52, 1'b1, 32'h2000_0004, 4'd6},  // R6 target, slot wrote r8
    {32'd56, 1'b0, 32'h0,         4'd8},  // R8 unknown opcode
    {32'd60, 1'b0, 32'h0,         4'd8},  // R8 other funct
    {32'd64, 1'b1, 32'h1000_0004, 4'd8},  // R8 r5 unchanged
    {32'd68, 1'b0, 32'h0,         4'd6},  // R6 backward beq
    {32'd72, 1'b1, 32'h2000_0008, 4'd6},  // R6 slot of backward beq
    {32'd0,  1'b1, 32'h0000_0010, 4'd6},  // R6 negative target
    {32'd4,  1'b1, 32'h0000_0020, 4'd2}   // R2
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int rq, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL R%0d %s actual 0x%08h expected 0x%08h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) imem[i] = 32'h0;
    imem[0]  = enc_lw(1, 0, 16'h0010);
    imem[1]  = enc_lw(2, 0, 16'h0020);
    imem[2]  = enc_add(3, 1, 2, 6'b100000);
    imem[3]  = enc_lw(4, 3, 16'h0000);
    imem[4]  = enc_add(0, 1, 2, 6'b100000);
    imem[5]  = enc_lw(5, 0, 16'h0004);
    imem[6]  = enc_lw(6, 1, 16'hFFF8);
    imem[7]  = enc_beq(1, 2, 16'h0005);
    imem[8]  = enc_lw(7, 4, 16'h0000);
    imem[9]  = enc_beq(1, 1, 16'h0003);
    imem[10] = enc_lw(8, 5, 16'h0000);
    imem[11] = enc_lw(9, 0, 16'h0000);
    imem[12] = enc_lw(9, 0, 16'h0000);
    imem[13] = enc_lw(10, 8, 16'h0000);
    imem[14] = {6'b001000, 5'd0, 5'd5, 16'h0077};
    imem[15] = enc_add(5, 1, 2, 6'b100010);
    imem[16] = enc_lw(11, 5, 16'h0000);
    imem[17] = enc_beq(0, 0, 16'hFFEE);
    imem[18] = enc_lw(12, 6, 16'h0000);
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    check(imem_addr, 32'h0, 1, "pc during reset");           // R1
    step();
    check(imem_addr, 32'h0, 1, "pc held in reset");          // R1
    release_reset();
    check(imem_addr, 32'h0, 1, "pc after release");          // R1

    for (int k = 0; k < NROWS; k++) begin
      check(imem_addr, EXP[k][68:37], int'(EXP[k][3:0]), $sformatf("pc row %0d", k));
      if (EXP[k][36])
        check(dmem_addr, EXP[k][35:4], int'(EXP[k][3:0]), $sformatf("load address row %0d", k));
      step();
    end

    // R1: reset while a taken redirect is pending cancels it
    rst_n = 1'b0;
    step();
    release_reset();
    for (int k = 0; k < 10; k++) step();
    check(imem_addr, 32'd40, 6, "slot pc before reset");     // R6
    rst_n = 1'b0;
    #1;
    check(imem_addr, 32'h0, 1, "async reset pc");            // R1
    release_reset();
    check(imem_addr, 32'h0, 1, "pc after second release");   // R1
    step();
    check(imem_addr, 32'd4, 1, "redirect cancelled by reset"); // R1
    check(dmem_addr, 32'h0000_0020, 4, "load after reset");  // R4

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule